// File: doc/BRIEF.md
# Width-Converting Saturating Integer Unit

This unit is one integer datapath stage for element-width-polymorphic arithmetic. It takes two 64-bit source operands. Each operand carries its own element width code, which says how many of its low bits are meaningful. Both operands are widened by sign or zero extension into a 65-bit internal form. The selected operation then runs at that full internal width, so no carry or borrow is lost.

Only after the operation is the wide result clamped to the destination element width, with signed or unsigned saturation. The clamped value is packed into the low bits of the output. When the record-flag input is set, an overflow flag reports whether clamping changed the value. Both results are registered and appear one cycle after a valid input, together with an output valid bit.

Signed saturation of the arithmetic operations reads the sign from the 65-bit result. For shift and exclusive-or, which carry no sign of their own, the sign is read from bit 63, the same place a 64-bit condition flag would look.

Top module: `wc_sat_alu`

## Requirements
- R1: A source operand keeps its low bits selected by its width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits); higher bits of the input are ignored. The kept bits are extended to 65 bits, with sign extension when `sext_i`=1 and zero extension when `sext_i`=0.
- R2: `op_i` selects the operation at 65 bits: 0 is add, 1 is subtract (a minus b) and 3 is exclusive-or. 2 is a logical left shift of extended a by the raw low 6 bits of `b_i`; the width code and extension of b are not applied to the shift amount.
- R3: With `sat_signed_i`=0, the 65-bit result is read as an unsigned number and clamped to the range 0 to 2^w-1, where w is the destination width. As a consequence, a negative difference clamps to the maximum.
- R4: With `sat_signed_i`=1 and an add or subtract, the 65-bit result is read as signed and clamped to the range -2^(w-1) to 2^(w-1)-1.
- R5: With `sat_signed_i`=1 and a shift or exclusive-or, bits 63..0 of the result are read as a signed 64-bit number and clamped to the same signed range as R4.
- R6: With `rc_i`=1, `ov_o` is 1 exactly when the clamped value differs from the unclamped result.
- R7: With `rc_i`=0, `ov_o` is 0.
- R8: `res_o` holds the clamped element in its low w bits, and all bits above w are 0.
- R9: `res_o` and `ov_o` update on the rising edge at which `valid_i`=1, and `valid_o` is 1 for the cycle that follows. When `valid_i`=0, `valid_o` goes to 0 and `res_o` and `ov_o` hold their values.
- R10: While `rst_ni` is low, `valid_o`, `res_o` and `ov_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input operands valid |
| op_i | input | 2 | Operation code |
| sat_signed_i | input | 1 | 1 = signed saturation, 0 = unsigned saturation |
| sext_i | input | 1 | 1 = sign extend sources, 0 = zero extend sources |
| a_wid_i | input | 2 | Element width code of source a |
| b_wid_i | input | 2 | Element width code of source b |
| d_wid_i | input | 2 | Element width code of the destination |
| a_i | input | 64 | Source operand a |
| b_i | input | 64 | Source operand b, or the shift amount |
| rc_i | input | 1 | Record flag: enables the overflow output |
| valid_o | output | 1 | Result valid |
| res_o | output | 64 | Saturated result element |
| ov_o | output | 1 | Overflow: clamping changed the value |

## Verification
Some rules are checked by the assertions on every cycle:
- the one-cycle valid pipeline and the holding of outputs while idle;
- the zero upper bits above the destination element;
- the overflow flag staying low when the record flag is clear;
- the absence of overflow for zero-extended unsigned additions of sources narrower than the destination.

Only the bench's vectors can show the clamped values themselves. These include the wrap of a negative difference to the unsigned maximum, and the carry into bit 64 at full width. They also include the contrast between the bit-64 sign used for add and subtract and the bit-63 sign used for shift and exclusive-or. Each of these needs an exact expected value worked out from the rules.

// File: rtl/wc_sat_pkg.sv
package wc_sat_pkg;
  localparam int unsigned NUM_WID = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_SLL = 2'd2,
    OP_XOR = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_e;

  // element width of lane code k, limited to the datapath width
  function automatic int unsigned lane_bits(int unsigned k, int unsigned xlen);
    int unsigned w;
    w = 8 << k;
    return (w > xlen) ? xlen : w;
  endfunction
endpackage

// File: rtl/wc_sat_ext.sv
module wc_sat_ext
  import wc_sat_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IW  = XLEN + 1
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [1:0]      wid_i,
  input  logic            sext_i,
  output logic [IW-1:0]   ext_o
);
  logic [IW-1:0] cand [NUM_WID];

  for (genvar k = 0; k < NUM_WID; k++) begin : g_wid
    localparam int unsigned W = lane_bits(k, XLEN);
    assign cand[k] = {{(IW-W){sext_i & val_i[W-1]}}, val_i[W-1:0]};
  end

  assign ext_o = cand[wid_i];
endmodule

// File: rtl/wc_sat_op.sv
module wc_sat_op
  import wc_sat_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IW  = XLEN + 1,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [1:0]     op_i,
  input  logic [IW-1:0]  ea_i,
  input  logic [IW-1:0]  eb_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [IW-1:0]  wide_o,
  output logic           unsigned_op_o
);
  always_comb begin
    wide_o        = '0;
    unsigned_op_o = 1'b0;
    case (op_e'(op_i))
      OP_ADD: wide_o = ea_i + eb_i;
      OP_SUB: wide_o = ea_i - eb_i;
      OP_SLL: begin
        wide_o        = ea_i << shamt_i;
        unsigned_op_o = 1'b1;
      end
      OP_XOR: begin
        wide_o        = ea_i ^ eb_i;
        unsigned_op_o = 1'b1;
      end
      default: wide_o = '0;
    endcase
  end
endmodule

// File: rtl/wc_sat_clamp.sv
module wc_sat_clamp
  import wc_sat_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IW  = XLEN + 1
) (
  input  logic [IW-1:0]   wide_i,
  input  logic            unsigned_op_i,
  input  logic            signed_i,
  input  logic [1:0]      d_wid_i,
  output logic [XLEN-1:0] sat_o,
  output logic            chg_o
);
  logic [IW-1:0] umax_t [NUM_WID];
  logic [IW-1:0] smax_t [NUM_WID];
  logic [IW-1:0] smin_t [NUM_WID];

  for (genvar k = 0; k < NUM_WID; k++) begin : g_lim
    localparam int unsigned W = lane_bits(k, XLEN);
    assign umax_t[k] = {{(IW-W){1'b0}}, {W{1'b1}}};
    assign smax_t[k] = {{(IW-W+1){1'b0}}, {(W-1){1'b1}}};
    assign smin_t[k] = {{(IW-W+1){1'b1}}, {(W-1){1'b0}}};
  end

  logic [IW-1:0] umax, smax, smin;
  logic [IW-1:0] ref_val, clamped;

  assign umax = umax_t[d_wid_i];
  assign smax = smax_t[d_wid_i];
  assign smin = smin_t[d_wid_i];

  // sign source: bit 64 for arithmetic, bit 63 for shift/xor
  always_comb begin
    if (signed_i && unsigned_op_i) ref_val = {wide_i[XLEN-1], wide_i[XLEN-1:0]};
    else                           ref_val = wide_i;
  end

  always_comb begin
    clamped = ref_val;
    if (signed_i) begin
      if ($signed(ref_val) > $signed(smax))      clamped = smax;
      else if ($signed(ref_val) < $signed(smin)) clamped = smin;
    end else if (ref_val > umax) begin
      clamped = umax;
    end
  end

  assign chg_o = (clamped != ref_val);
  assign sat_o = clamped[XLEN-1:0] & umax[XLEN-1:0];
endmodule

// File: rtl/wc_sat_alu.sv
module wc_sat_alu
  import wc_sat_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IW  = XLEN + 1,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic            sat_signed_i,
  input  logic            sext_i,
  input  logic [1:0]      a_wid_i,
  input  logic [1:0]      b_wid_i,
  input  logic [1:0]      d_wid_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            rc_i,
  output logic            valid_o,
  output logic [XLEN-1:0] res_o,
  output logic            ov_o
);
  logic [IW-1:0]   ea, eb, wide;
  logic            unsigned_op, chg;
  logic [XLEN-1:0] sat;

  wc_sat_ext #(.XLEN(XLEN)) i_ext_a (
    .val_i(a_i), .wid_i(a_wid_i), .sext_i(sext_i), .ext_o(ea)
  );

  wc_sat_ext #(.XLEN(XLEN)) i_ext_b (
    .val_i(b_i), .wid_i(b_wid_i), .sext_i(sext_i), .ext_o(eb)
  );

  wc_sat_op #(.XLEN(XLEN)) i_op (
    .op_i(op_i), .ea_i(ea), .eb_i(eb), .shamt_i(b_i[SHW-1:0]),
    .wide_o(wide), .unsigned_op_o(unsigned_op)
  );

  wc_sat_clamp #(.XLEN(XLEN)) i_clamp (
    .wide_i(wide), .unsigned_op_i(unsigned_op), .signed_i(sat_signed_i),
    .d_wid_i(d_wid_i), .sat_o(sat), .chg_o(chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      ov_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= sat;
        ov_o  <= rc_i & chg;
      end
    end
  end
endmodule

// File: rtl/wc_sat_alu_chk.sv
module wc_sat_alu_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [1:0]      op_i,
  input logic            sat_signed_i,
  input logic            sext_i,
  input logic [1:0]      a_wid_i,
  input logic [1:0]      b_wid_i,
  input logic [1:0]      d_wid_i,
  input logic            rc_i,
  input logic            valid_o,
  input logic [XLEN-1:0] res_o,
  input logic            ov_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rc_i && op_i == 2'd0 && !sat_signed_i && !sext_i &&
     a_wid_i < d_wid_i && b_wid_i < d_wid_i) |=> !ov_o); // R3

  AST_RC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rc_i) |=> !ov_o); // R7

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9

  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(ov_o))); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($past(d_wid_i) == 2'd3 ||
                 (res_o >> (8 << $past(d_wid_i))) == '0)); // R8
endmodule

bind wc_sat_alu wc_sat_alu_chk #(.XLEN(XLEN)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .sat_signed_i(sat_signed_i), .sext_i(sext_i), .a_wid_i(a_wid_i),
  .b_wid_i(b_wid_i), .d_wid_i(d_wid_i), .rc_i(rc_i), .valid_o(valid_o),
  .res_o(res_o), .ov_o(ov_o)
);

// File: tb/test_wc_sat_alu.sv
`timescale 1ns/1ps
module test_wc_sat_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        sat_signed_i = 1'b0;
  logic        sext_i = 1'b0;
  logic [1:0]  a_wid_i = '0, b_wid_i = '0, d_wid_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        rc_i = 1'b0;
  logic        valid_o;
  logic [63:0] res_o;
  logic        ov_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  wc_sat_alu i_wc_sat_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .sat_signed_i(sat_signed_i), .sext_i(sext_i), .a_wid_i(a_wid_i),
    .b_wid_i(b_wid_i), .d_wid_i(d_wid_i), .a_i(a_i), .b_i(b_i), .rc_i(rc_i),
    .valid_o(valid_o), .res_o(res_o), .ov_o(ov_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        ss;
    logic        sx;
    logic [1:0]  aw;
    logic [1:0]  bw;
    logic [1:0]  dw;
    logic        rc;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        ov;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b1,64'hF0,64'h20,64'hFF,1'b1},              // R3 R6 unsigned clamp
    '{2'd0,1'b0,1'b0,2'd0,2'd0,2'd1,1'b1,64'hF0,64'h20,64'h110,1'b0},             // R3 fits 16 bits
    '{2'd1,1'b0,1'b0,2'd0,2'd0,2'd0,1'b1,64'h3,64'h5,64'hFF,1'b1},                // R3 negative -> max
    '{2'd1,1'b1,1'b1,2'd0,2'd0,2'd0,1'b1,64'h3,64'h5,64'hFE,1'b0},                // R4 R8 -2 in range
    '{2'd0,1'b1,1'b1,2'd0,2'd0,2'd0,1'b1,64'h7F,64'h1,64'h7F,1'b1},               // R4 positive clamp
    '{2'd1,1'b1,1'b1,2'd0,2'd0,2'd0,1'b1,64'h80,64'h1,64'h80,1'b1},               // R4 negative clamp
    '{2'd0,1'b1,1'b1,2'd3,2'd3,2'd3,1'b1,64'h7FFF_FFFF_FFFF_FFFF,64'h1,64'h7FFF_FFFF_FFFF_FFFF,1'b1}, // R4 carry kept
    '{2'd0,1'b0,1'b0,2'd3,2'd3,2'd3,1'b1,64'hFFFF_FFFF_FFFF_FFFF,64'h1,64'hFFFF_FFFF_FFFF_FFFF,1'b1}, // R3 carry kept
    '{2'd0,1'b0,1'b0,2'd0,2'd1,2'd1,1'b1,64'h1234_5680,64'hFF00,64'hFF80,1'b0},   // R1 zero extend
    '{2'd0,1'b1,1'b1,2'd0,2'd1,2'd1,1'b1,64'h1234_5680,64'hFF00,64'hFE80,1'b0},   // R1 sign extend
    '{2'd2,1'b1,1'b0,2'd3,2'd0,2'd3,1'b1,64'h4000_0000_0000_0000,64'h1,64'h8000_0000_0000_0000,1'b0}, // R5 bit 63 sign
    '{2'd2,1'b1,1'b0,2'd0,2'd0,2'd0,1'b1,64'h40,64'h1,64'h7F,1'b1},               // R5 shift clamp
    '{2'd3,1'b1,1'b0,2'd3,2'd3,2'd1,1'b1,64'hFFFF_FFFF_FFFF_0000,64'h1234,64'h8000,1'b1}, // R5 xor negative
    '{2'd0,1'b1,1'b0,2'd3,2'd3,2'd1,1'b1,64'hFFFF_FFFF_FFFF_0000,64'h1234,64'h7FFF,1'b1}, // R4 add positive
    '{2'd3,1'b0,1'b0,2'd1,2'd1,2'd2,1'b1,64'hF0F0,64'h0F0F,64'hFFFF,1'b0},        // R2 xor
    '{2'd2,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,64'h3,64'h41,64'h6,1'b0},                // R2 raw shift amount
    '{2'd0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,64'hF0,64'h20,64'hFF,1'b0}               // R7 record off
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_i = v.op; sat_signed_i = v.ss; sext_i = v.sx;
    a_wid_i = v.aw; b_wid_i = v.bw; d_wid_i = v.dw;
    a_i = v.a; b_i = v.b; rc_i = v.rc;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state, with valid held high
    valid_i = 1'b1;
    drive(VEC[0]);
    @(negedge clk_i);
    chk(!valid_o && res_o == '0 && !ov_o, "R10 reset", {valid_o, ov_o, res_o[61:0]}, 64'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && res_o == '0, "R10 after release", res_o, 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      valid_i = 1'b1;
      @(negedge clk_i);
      chk(valid_o == 1'b1, $sformatf("R9 valid vec %0d", i), {63'd0, valid_o}, 64'd1);
      chk(res_o == VEC[i].res, $sformatf("res vec %0d", i), res_o, VEC[i].res);
      chk(ov_o == VEC[i].ov, $sformatf("R6 ov vec %0d", i), {63'd0, ov_o}, {63'd0, VEC[i].ov});
    end

    // R9 hold while idle: change inputs, outputs must not move
    valid_i = 1'b0;
    drive(VEC[0]);
    @(negedge clk_i);
    chk(!valid_o, "R9 valid drop", {63'd0, valid_o}, 64'd0);
    chk(res_o == VEC[NV-1].res && !ov_o, "R9 hold", res_o, VEC[NV-1].res);
    @(negedge clk_i);
    chk(res_o == VEC[NV-1].res, "R9 hold 2", res_o, VEC[NV-1].res);

    // R8 upper bits cleared after a wide then narrow result
    drive(VEC[7]);
    valid_i = 1'b1;
    @(negedge clk_i);
    drive(VEC[3]);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(res_o == 64'hFE, "R8 upper zero", res_o, 64'hFE);

    // R7 record off on a saturating signed case
    drive(VEC[4]);
    rc_i = 1'b0;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(!ov_o && res_o == 64'h7F, "R7 ov gated", {63'd0, ov_o}, 64'd0);

    // R10 asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk(!valid_o && res_o == '0 && !ov_o, "R10 async reset", res_o, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule